// File: doc/BRIEF.md
# Multi-Event Buffer Ring Pointer Controller

This block keeps track of a circular ring of 64 event buffers in a gated acquisition front end. A fill index names the buffer that the next digitising gate will use, and a drain index names the buffer most recently handed to readout. A completed gate moves the fill index on. A load-next command moves the drain index on and copies the length of that event into a 7-bit word counter. Each word moved by a block-transfer readout then counts the counter down. The ring derives full and empty flags from the two indices. When the ring is full it refuses new gates, unless overrun protection is switched off for bench setup. In that mode it wraps from full straight back to empty.

Gate completions arrive over a valid/ready pair. The upstream side raises `gate_vld` for one cycle per finished gate. The gate counts only in a cycle where `gate_rdy` is also high. `gate_rdy` is low exactly when the ring is full and overrun protection is on. A gate offered while `gate_rdy` is low is dropped, not queued. The upstream side must therefore hold off or veto gates while `gate_rdy` is low. Load-next and word strobes are plain single-cycle pulses. A small register port lets software read and overwrite the index pair and the word counter.

Top module: `evb_ptr_ctrl`

## Requirements
- R1: After reset the index register reads 0x00003F00 (drain index 63, fill index 0), the word counter reads 0, `empty` is 1, `full` is 0 and `xfer_done` is 0.
- R2: A cycle with `gate_vld` and `gate_rdy` both high, and no index-register write, advances `wr_idx` by one modulo 64 at the next clock edge.
- R3: `full` is 1 exactly when `wr_idx` equals `rd_idx`. `empty` is 1 exactly when `rd_idx`+1 (mod 64) equals `wr_idx`. With `ovr_dis`=0 and `full`=1, `gate_rdy` is 0 and an offered gate leaves `wr_idx` unchanged.
- R4: With `ovr_dis`=1, `gate_rdy` stays 1 when full. An accepted gate at full moves `wr_idx` on, and the ring becomes empty.
- R5: A `ld_next` pulse while not empty, with no index-register write, advances `rd_idx` by one modulo 64 (63 wraps to 0) and loads the word counter from `nxt_len`. A `ld_next` pulse while empty changes neither the index nor the counter.
- R6: A `xfer` pulse, with no counter write and no accepted load, lowers a nonzero counter by one. At zero the counter stays at zero.
- R7: `xfer_done` is high for exactly the one cycle that follows a decrement which took the counter from 1 to 0.
- R8: With `reg_sel`=0, `reg_rdata` holds `rd_idx` in bits 13:8 and `wr_idx` in bits 5:0, with all other bits zero. With `reg_sel`=1, `reg_rdata` holds the counter in bits 6:0, with all other bits zero.
- R9: A write with `reg_wr`=1 and `reg_sel`=0 loads `rd_idx` from `reg_wdata[13:8]` and `wr_idx` from `reg_wdata[5:0]`. This write takes priority over a gate or a load in the same cycle, for both indices. All other written bits are ignored.
- R10: A write with `reg_wr`=1 and `reg_sel`=1 loads the counter from `reg_wdata[6:0]`. It takes priority over a load or a word strobe in the same cycle, and it raises no `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ovr_dis | input | 1 | 1 disables overrun protection (setup use only) |
| gate_vld | input | 1 | A digitising gate has completed |
| gate_rdy | output | 1 | Ring can accept a gate |
| ld_next | input | 1 | Load-next-event command strobe |
| nxt_len | input | 7 | Word length of the next event to be read |
| xfer | input | 1 | One block-transfer word moved |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the index register, 1 selects the word counter |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| rd_idx | output | 6 | Drain index (last buffer handed to readout) |
| wr_idx | output | 6 | Fill index (next buffer to be filled) |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| word_cnt | output | 7 | Remaining words of the current event |
| xfer_done | output | 1 | Counter reached zero on the previous word |

## Verification
The indices, the counter and `xfer_done` are registered. Their new values are due one clock edge after the strobe. `full`, `empty`, `gate_rdy` and `reg_rdata` are combinational from that state and from `reg_sel`/`ovr_dis`, so they follow in the same cycle. The bench applies each stimulus on a falling edge. It checks `gate_rdy` shortly after that edge, before the rising edge. It checks every registered result and flag 1 ns after the rising edge that should update them, while the inputs are still held. The expected values come from a small arithmetic model of the indices and the counter that the bench updates once per edge.

// File: rtl/evb_pkg.sv
package evb_pkg;
  typedef enum logic {
    SEL_IDX = 1'b0,
    SEL_CNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/evb_ring_idx.sv
module evb_ring_idx #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_dis,
  input  logic             gate_vld,
  input  logic             ld_req,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_wr_rd,
  input  logic [IDX_W-1:0] idx_wr_wr,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic             gate_rdy,
  output logic             full,
  output logic             empty,
  output logic             ld_acc
);
  logic [IDX_W-1:0] rd_q, wr_q, rd_inc, wr_inc;
  logic             gate_acc;

  assign rd_inc   = rd_q + 1'b1;
  assign wr_inc   = wr_q + 1'b1;
  assign full     = (wr_q == rd_q);
  assign empty    = (rd_inc == wr_q);
  assign gate_rdy = !full || ovr_dis;
  assign gate_acc = gate_vld && gate_rdy;
  assign ld_acc   = ld_req && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '1;
      wr_q <= '0;
    end else if (idx_wr) begin
      rd_q <= idx_wr_rd;
      wr_q <= idx_wr_wr;
    end else begin
      if (gate_acc) wr_q <= wr_inc;
      if (ld_acc)   rd_q <= rd_inc;
    end
  end

  assign rd_idx = rd_q;
  assign wr_idx = wr_q;

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_vld && gate_rdy && !idx_wr) |=> wr_idx == IDX_W'($past(wr_idx) + 1'b1)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ovr_dis && !idx_wr) |=> $stable(wr_idx)); // R3
  AST_EMPTY_HOLDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !idx_wr) |=> $stable(rd_idx)); // R5
  AST_IDX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (rd_idx == $past(idx_wr_rd)) && (wr_idx == $past(idx_wr_wr))); // R9
endmodule

// File: rtl/evb_word_cnt.sv
module evb_word_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_acc,
  input  logic [CNT_W-1:0] nxt_len,
  input  logic             xfer,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] word_cnt,
  output logic             xfer_done
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, dec_ok;

  assign dec_ok = xfer && !cnt_wr && !ld_acc && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= dec_ok && (cnt_q == CNT_W'(1));
      if (cnt_wr)      cnt_q <= cnt_wdata;
      else if (ld_acc) cnt_q <= nxt_len;
      else if (dec_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign word_cnt  = cnt_q;
  assign xfer_done = done_q;

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && word_cnt == '0 && !cnt_wr && !ld_acc) |=> word_cnt == '0); // R6
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> word_cnt == '0); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R7
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (word_cnt == $past(cnt_wdata)) && !xfer_done); // R10
endmodule

// File: rtl/evb_reg_view.sv
module evb_reg_view
  import evb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 7,
  parameter int RD_LSB = 8,
  parameter int WR_LSB = 0
) (
  input  logic             sel,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] word_cnt,
  output logic [DW-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (reg_sel_e'(sel) == SEL_IDX) begin
      rdata[RD_LSB +: IDX_W] = rd_idx;
      rdata[WR_LSB +: IDX_W] = wr_idx;
    end else begin
      rdata[CNT_W-1:0] = word_cnt;
    end
  end

  always_comb begin
    if (reg_sel_e'(sel) == SEL_CNT)
      AST_CNT_VIEW_ZERO_TOP: assert (rdata[DW-1:CNT_W] == '0); // R8
  end
endmodule

// File: rtl/evb_ptr_ctrl.sv
module evb_ptr_ctrl
  import evb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 7,
  parameter int RD_LSB = 8,
  parameter int WR_LSB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_dis,
  input  logic             gate_vld,
  output logic             gate_rdy,
  input  logic             ld_next,
  input  logic [CNT_W-1:0] nxt_len,
  input  logic             xfer,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] word_cnt,
  output logic             xfer_done
);
  localparam int TOP_USED = RD_LSB + IDX_W;

  logic idx_wr, cnt_wr, ld_acc;
  logic unused_wdata;

  assign idx_wr       = reg_wr && (reg_sel_e'(reg_sel) == SEL_IDX);
  assign cnt_wr       = reg_wr && (reg_sel_e'(reg_sel) == SEL_CNT);
  assign unused_wdata = ^reg_wdata[DW-1:TOP_USED];

  evb_ring_idx #(.IDX_W(IDX_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovr_dis   (ovr_dis),
    .gate_vld  (gate_vld),
    .ld_req    (ld_next),
    .idx_wr    (idx_wr),
    .idx_wr_rd (reg_wdata[RD_LSB +: IDX_W]),
    .idx_wr_wr (reg_wdata[WR_LSB +: IDX_W]),
    .rd_idx    (rd_idx),
    .wr_idx    (wr_idx),
    .gate_rdy  (gate_rdy),
    .full      (full),
    .empty     (empty),
    .ld_acc    (ld_acc)
  );

  evb_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_acc    (ld_acc),
    .nxt_len   (nxt_len),
    .xfer      (xfer),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .word_cnt  (word_cnt),
    .xfer_done (xfer_done)
  );

  evb_reg_view #(
    .DW(DW), .IDX_W(IDX_W), .CNT_W(CNT_W), .RD_LSB(RD_LSB), .WR_LSB(WR_LSB)
  ) u_view (
    .sel      (reg_sel),
    .rd_idx   (rd_idx),
    .wr_idx   (wr_idx),
    .word_cnt (word_cnt),
    .rdata    (reg_rdata)
  );

  AST_FLAG_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3
  AST_LOAD_TAKES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_next && !empty && !reg_wr) |=> word_cnt == $past(nxt_len)); // R5
  AST_OVR_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_dis |-> gate_rdy); // R4
endmodule

// File: tb/tb_evb_ptr_ctrl.sv
`timescale 1ns/1ps
module tb_evb_ptr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ovr_dis = 0, gate_vld = 0, ld_next = 0, xfer = 0, reg_wr = 0, reg_sel = 0;
  logic [6:0] nxt_len = '0;
  logic [31:0] reg_wdata = '0;
  logic gate_rdy, full, empty, xfer_done;
  logic [31:0] reg_rdata;
  logic [5:0] rd_idx, wr_idx;
  logic [6:0] word_cnt;

  int n_cmp = 0, n_bad = 0;
  logic [5:0] m_rd, m_wr;
  logic [6:0] m_cnt;
  logic m_done;

  always #2.5 clk = ~clk;

  evb_ptr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ovr_dis(ovr_dis), .gate_vld(gate_vld), .gate_rdy(gate_rdy),
    .ld_next(ld_next), .nxt_len(nxt_len), .xfer(xfer), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_idx(rd_idx), .wr_idx(wr_idx),
    .full(full), .empty(empty), .word_cnt(word_cnt), .xfer_done(xfer_done)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_full();  return m_wr == m_rd; endfunction
  function automatic logic m_empty(); return 6'(m_rd + 1'b1) == m_wr; endfunction

  task automatic check_state();
    chk(32'(rd_idx), 32'(m_rd), "R5/R9 rd_idx");
    chk(32'(wr_idx), 32'(m_wr), "R2/R9 wr_idx");
    chk(32'(full), 32'(m_full()), "R3 full");
    chk(32'(empty), 32'(m_empty()), "R3 empty");
    chk(32'(word_cnt), 32'(m_cnt), "R6/R10 word_cnt");
    chk(32'(xfer_done), 32'(m_done), "R7 xfer_done");
    chk(reg_rdata, reg_sel ? {25'b0, m_cnt} : {18'b0, m_rd, 2'b0, m_wr}, "R8 reg_rdata");
  endtask

  task automatic step(input logic g, input logic l, input logic [6:0] len, input logic x,
                      input logic w, input logic s, input logic [31:0] wd, input logic od);
    logic acc, lacc;
    @(negedge clk);
    gate_vld = g; ld_next = l; nxt_len = len; xfer = x;
    reg_wr = w; reg_sel = s; reg_wdata = wd; ovr_dis = od;
    #1;
    chk(32'(gate_rdy), 32'(!m_full() || od), "R3/R4 gate_rdy");
    acc  = g && (!m_full() || od);
    lacc = l && !m_empty();
    m_done = !(w && s) && !lacc && x && (m_cnt == 7'd1);
    if (w && !s) begin
      m_rd = wd[13:8]; m_wr = wd[5:0];
    end else begin
      if (acc)  m_wr = m_wr + 1'b1;
      if (lacc) m_rd = m_rd + 1'b1;
    end
    if (w && s)                m_cnt = wd[6:0];
    else if (lacc)             m_cnt = len;
    else if (x && m_cnt != 0)  m_cnt = m_cnt - 1'b1;
    @(posedge clk); #1;
    check_state();
  endtask

  task automatic idle(input logic s);
    step(0, 0, 7'd0, 0, 0, s, 32'd0, 0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_rd = 6'd63; m_wr = 6'd0; m_cnt = 7'd0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(reg_rdata, 32'h00003F00, "R1 idx reg reset");
    chk(32'(empty), 32'd1, "R1 empty");
    chk(32'(full), 32'd0, "R1 full");
    chk(32'(word_cnt), 32'd0, "R1 count");
    chk(32'(xfer_done), 32'd0, "R1 done");
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    chk(reg_rdata, 32'd0, "R1 count view after reset");

    // R2 R3: fill ring completely, one gate at a time
    for (int i = 0; i < 63; i++) step(1, 0, 7'd0, 0, 0, 0, 32'd0, 0);
    chk(32'(full), 32'd1, "R3 full after 63 gates");
    // R3: gates refused while full
    for (int i = 0; i < 3; i++) step(1, 0, 7'd0, 0, 0, 0, 32'd0, 0);
    chk(32'(wr_idx), 32'd63, "R3 wr held at full");
    // R4: overrun disabled, full wraps to empty
    step(1, 0, 7'd0, 0, 0, 0, 32'd0, 1);
    chk(32'(empty), 32'd1, "R4 wrap to empty");
    // R5: load while empty ignored
    step(0, 1, 7'd9, 0, 0, 1, 32'd0, 0);
    chk(32'(word_cnt), 32'd0, "R5 empty load ignored");

    // R9 + R3 sweep: every fill index against a fixed drain index
    for (int k = 0; k < 64; k++) step(0, 0, 7'd0, 0, 1, 0, {18'h3FFFF, 6'd20, 2'b11, 6'(k)}, 0);
    // R9: write beats gate and load in same cycle
    step(1, 1, 7'd3, 0, 1, 0, {16'hFFFF, 2'b11, 6'd10, 2'b00, 6'd20}, 0);
    // gate + load together
    step(1, 1, 7'd5, 0, 0, 0, 32'd0, 0);
    // R6 R7: drain 5 words plus extra
    for (int i = 0; i < 7; i++) step(0, 0, 7'd0, 1, 0, i[0], 32'd0, 0);
    // R5 lengths sweep with full drain each
    for (int len = 0; len < 4; len++) begin
      step(0, 1, 7'(len), 0, 0, 1, 32'd0, 0);
      for (int i = 0; i <= len; i++) step(0, 0, 7'd0, 1, 0, 1, 32'd0, 0);
    end
    // R5: load wins over xfer
    step(0, 1, 7'd1, 1, 0, 1, 32'd0, 0);
    // R10: count write beats load and xfer
    step(0, 1, 7'd44, 1, 1, 1, 32'hFFFF_FF80 | 32'd100, 0);
    chk(32'(word_cnt), 32'd100, "R10 count write value");
    step(0, 0, 7'd0, 0, 1, 1, 32'd1, 0);
    step(0, 0, 7'd0, 1, 1, 1, 32'd7, 0);
    chk(32'(xfer_done), 32'd0, "R10 no done on write");
    // R5 drain index wraps 63 -> 0 -> 1, then empty
    step(0, 0, 7'd0, 0, 1, 0, {18'd0, 6'd62, 2'd0, 6'd2}, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 7'(i + 11), 0, 0, i[0], 32'd0, 0);
    chk(32'(rd_idx), 32'd1, "R5 rd wrap");
    // R9 all-ones write: full, upper bits ignored
    step(0, 0, 7'd0, 0, 1, 0, 32'hFFFF_FFFF, 0);
    chk(reg_rdata, 32'h00003F3F, "R9 upper bits ignored");
    step(1, 0, 7'd0, 0, 0, 0, 32'd0, 0);
    step(1, 0, 7'd0, 0, 0, 0, 32'd0, 1);
    idle(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule